// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks where each of the two ALU operands of the instruction in the execute stage comes from in a five-stage, single-issue, in-order load/store pipeline. Each source register number of the executing instruction is compared with the destination register numbers held further down the pipe. One is in the execute/memory pipeline register and one is in the memory/writeback pipeline register. When a match is found and that stage will write a register, the newer result is steered onto the operand at once. The dependent instruction does not wait for the value to reach the register file. A dependent instruction issued right after its producer therefore sees the new value (for example 0x20 in place of an old 0x10) in its own execute cycle, one cycle before the producer writes back.

The register file is part of the harness. Its two decode-stage read ports pass the writeback value straight through when they read the register being written in the same cycle. The operand muxes are also built in, so the selected operand values are visible at the ports.

The block has no state machine. Forwarding selection is purely combinational. The only clocked state is the register array, which has two conditions. After reset every register is cleared to zero. In normal operation a register is updated on each clock edge where writeback is enabled with a non-zero destination.

Top module: `fwd_unit`

## Requirements
- R1: Each operand select is a 2-bit code: 00 takes the value latched from the register file (`ex_rf_a`/`ex_rf_b`), 10 takes the execute/memory ALU result (`exm_result`), 01 takes the writeback value (`wb_value`). Code 11 never appears. The operand output always equals the source named by its select.
- R2: When an operand's source number equals `exm_dst`, `exm_wen` is 1 and `exm_dst` is non-zero, that operand's select is 10.
- R3: When only the memory/writeback stage matches (`wb_dst` equal, `wb_wen` 1, `wb_dst` non-zero), the select is 01.
- R4: When both stages match the same source, the execute/memory stage wins and the select is 10.
- R5: A stage whose write-enable is 0 is never forwarded from, even if its destination matches.
- R6: A destination of register 0 is never forwarded from, even with its write-enable at 1. The select stays 00.
- R7: The two operands are resolved independently. Each can take a different source in the same cycle.
- R8: On a clock edge with `wb_wen` at 1 and `wb_dst` non-zero, register `wb_dst` takes `wb_value`. Reads of register 0 return 0 and writes to it are dropped.
- R9: A decode read of the register being written in the same cycle (with `wb_wen` at 1 and a non-zero address) returns `wb_value`, not the stored value.
- R10: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_src_a | input | 5 | First source register number of the instruction in execute |
| ex_src_b | input | 5 | Second source register number of the instruction in execute |
| ex_rf_a | input | 32 | First operand value latched from the register file |
| ex_rf_b | input | 32 | Second operand value latched from the register file |
| exm_dst | input | 5 | Destination number in the execute/memory register |
| exm_wen | input | 1 | Register-write control in the execute/memory register |
| exm_result | input | 32 | ALU result in the execute/memory register |
| wb_dst | input | 5 | Destination number in the memory/writeback register |
| wb_wen | input | 1 | Register-write control in the memory/writeback register |
| wb_value | input | 32 | Value being written back |
| id_raddr_a | input | 5 | Decode read address, port A |
| id_raddr_b | input | 5 | Decode read address, port B |
| id_rdata_a | output | 32 | Decode read data, port A |
| id_rdata_b | output | 32 | Decode read data, port B |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench targets the case where both stages match the same source. A design that ranked the stages the wrong way would hand the ALU the older writeback value. It also drives a matching destination with write-enable low, and a matching destination of register 0 with write-enable high. A design that ignored either guard would forward a result that was never going to be written. Further tests give the two operands different sources in one cycle to expose any cross-coupling between them. A same-cycle decode read of the register under write exposes a register file without the bypass, which would return the stale stored value.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] exm_dst,
    input  logic          exm_wen,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wen,
    output fwd_sel_e      sel
);
    logic hit_exm;
    logic hit_wb;

    always_comb begin
        hit_exm = exm_wen && (exm_dst != '0) && (exm_dst == src);
        hit_wb  = wb_wen  && (wb_dst  != '0) && (wb_dst  == src);
        if (hit_exm)
            sel = SEL_EXM;      // youngest producer first
        else if (hit_wb)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fwd_sel_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] exm_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] out
);
    always_comb begin
        unique case (sel)
            SEL_EXM: out = exm_val;
            SEL_WB:  out = wb_val;
            SEL_RF:  out = rf_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/wt_regfile.sv
module wt_regfile #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NREAD = 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wen,
    input  logic [AW-1:0]         waddr,
    input  logic [XLEN-1:0]       wdata,
    input  logic [NREAD-1:0][AW-1:0]   raddr,
    output logic [NREAD-1:0][XLEN-1:0] rdata
);
    logic [XLEN-1:0] regs [NREG];
    logic            wr_live;

    assign wr_live = wen && (waddr != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_live) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0)
                rdata[p] = '0;
            else if (wr_live && (raddr[p] == waddr))
                rdata[p] = wdata;       // write-through in the same cycle
            else
                rdata[p] = regs[raddr[p]];
        end

        p_zero_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (raddr[p] == '0) |-> (rdata[p] == '0));
        p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wen && (waddr != '0) && (raddr[p] == waddr)) |-> (rdata[p] == wdata));
        p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wen && (waddr != '0) && (raddr[p] == waddr))
            |=> ((raddr[p] != $past(waddr)) || wen || (rdata[p] == $past(wdata))));
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int NOP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ex_src_a,
    input  logic [AW-1:0]   ex_src_b,
    input  logic [XLEN-1:0] ex_rf_a,
    input  logic [XLEN-1:0] ex_rf_b,
    input  logic [AW-1:0]   exm_dst,
    input  logic            exm_wen,
    input  logic [XLEN-1:0] exm_result,
    input  logic [AW-1:0]   wb_dst,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_value,
    input  logic [AW-1:0]   id_raddr_a,
    input  logic [AW-1:0]   id_raddr_b,
    output logic [XLEN-1:0] id_rdata_a,
    output logic [XLEN-1:0] id_rdata_b,
    output logic [1:0]      sel_a,
    output logic [1:0]      sel_b,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b
);
    logic [NOP-1:0][AW-1:0]   src;
    logic [NOP-1:0][XLEN-1:0] rfv;
    logic [NOP-1:0][XLEN-1:0] outv;
    fwd_sel_e                 sel [NOP];
    logic [1:0][AW-1:0]       rd_addr;
    logic [1:0][XLEN-1:0]     rd_data;

    assign src[0] = ex_src_a;
    assign src[1] = ex_src_b;
    assign rfv[0] = ex_rf_a;
    assign rfv[1] = ex_rf_b;

    for (genvar k = 0; k < NOP; k++) begin : g_op
        fwd_select #(.AW(AW)) u_sel (
            .src     (src[k]),
            .exm_dst (exm_dst),
            .exm_wen (exm_wen),
            .wb_dst  (wb_dst),
            .wb_wen  (wb_wen),
            .sel     (sel[k])
        );
        fwd_mux #(.XLEN(XLEN)) u_mux (
            .sel     (sel[k]),
            .rf_val  (rfv[k]),
            .exm_val (exm_result),
            .wb_val  (wb_value),
            .out     (outv[k])
        );
    end

    assign sel_a  = sel[0];
    assign sel_b  = sel[1];
    assign opnd_a = outv[0];
    assign opnd_b = outv[1];

    assign rd_addr[0] = id_raddr_a;
    assign rd_addr[1] = id_raddr_b;

    wt_regfile #(.XLEN(XLEN), .NREG(NREG), .NREAD(2)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (wb_wen),
        .waddr (wb_dst),
        .wdata (wb_value),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign id_rdata_a = rd_data[0];
    assign id_rdata_b = rd_data[1];

    p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11));
    p_exm_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_wen && (exm_dst != '0) && (exm_dst == ex_src_a)) |-> (opnd_a == exm_result));
    p_no_zero_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a == '0) |-> (opnd_a == ex_rf_a));
    p_wb_needs_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 2'b01) |-> (wb_wen && (wb_dst == ex_src_b)));
    p_exm_needs_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 2'b10) |-> (exm_wen && (exm_dst == ex_src_b)));
endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ex_src_a = '0, ex_src_b = '0, exm_dst = '0, wb_dst = '0;
    logic [4:0]  id_raddr_a = '0, id_raddr_b = '0;
    logic        exm_wen = 1'b0, wb_wen = 1'b0;
    logic [31:0] ex_rf_a = 32'h10, ex_rf_b = 32'h11;
    logic [31:0] exm_result = 32'h20, wb_value = 32'h30;
    logic [31:0] id_rdata_a, id_rdata_b, opnd_a, opnd_b;
    logic [1:0]  sel_a, sel_b;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fwd_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
        .exm_dst(exm_dst), .exm_wen(exm_wen), .exm_result(exm_result),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_value(wb_value),
        .id_raddr_a(id_raddr_a), .id_raddr_b(id_raddr_b),
        .id_rdata_a(id_rdata_a), .id_rdata_b(id_rdata_b),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                         input logic [4:0] ed, input logic ew,
                         input logic [4:0] wd, input logic ww);
        @(negedge clk);
        ex_src_a = sa; ex_src_b = sb;
        exm_dst = ed; exm_wen = ew;
        wb_dst = wd; wb_wen = ww;
        #1;
    endtask

    task automatic t_reset;
        for (int r = 0; r < 32; r += 7) begin
            id_raddr_a = 5'(r); id_raddr_b = 5'(r + 1);
            #1;
            chk("R10 reset a", id_rdata_a, 32'h0);
            chk("R10 reset b", id_rdata_b, 32'h0);
        end
    endtask

    task automatic t_none;
        drive(5'd3, 5'd4, 5'd7, 1'b1, 5'd8, 1'b1);
        chk("R1 sel_a rf", 32'(sel_a), 32'h0);
        chk("R1 opnd_a rf", opnd_a, 32'h10);
        chk("R1 opnd_b rf", opnd_b, 32'h11);
    endtask

    task automatic t_exm;
        drive(5'd2, 5'd9, 5'd2, 1'b1, 5'd0, 1'b0);
        chk("R2 sel_a exm", 32'(sel_a), 32'h2);
        chk("R2 opnd_a exm", opnd_a, 32'h20);
        drive(5'd9, 5'd2, 5'd2, 1'b1, 5'd0, 1'b0);
        chk("R2 opnd_b exm", opnd_b, 32'h20);
    endtask

    task automatic t_wb;
        drive(5'd6, 5'd6, 5'd1, 1'b1, 5'd6, 1'b1);
        chk("R3 sel_a wb", 32'(sel_a), 32'h1);
        chk("R3 opnd_a wb", opnd_a, 32'h30);
        chk("R3 opnd_b wb", opnd_b, 32'h30);
    endtask

    task automatic t_both;
        drive(5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1);
        chk("R4 sel_a both", 32'(sel_a), 32'h2);
        chk("R4 opnd_a both", opnd_a, 32'h20);
        chk("R4 opnd_b both", opnd_b, 32'h20);
    endtask

    task automatic t_nowen;
        drive(5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0);
        chk("R5 opnd_a no wen", opnd_a, 32'h10);
        chk("R5 sel_b no wen", 32'(sel_b), 32'h0);
        drive(5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b1);
        chk("R5 exm off, wb on", opnd_a, 32'h30);
    endtask

    task automatic t_zero;
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        chk("R6 zero a", opnd_a, 32'h10);
        chk("R6 zero sel_b", 32'(sel_b), 32'h0);
        wb_wen = 1'b0;
    endtask

    task automatic t_indep;
        drive(5'd12, 5'd13, 5'd12, 1'b1, 5'd13, 1'b1);
        chk("R7 opnd_a exm", opnd_a, 32'h20);
        chk("R7 opnd_b wb", opnd_b, 32'h30);
        drive(5'd13, 5'd12, 5'd12, 1'b1, 5'd13, 1'b1);
        chk("R7 swapped a", opnd_a, 32'h30);
        chk("R7 swapped b", opnd_b, 32'h20);
    endtask

    task automatic t_regfile;
        exm_wen = 1'b0;
        drive(5'd1, 5'd1, 5'd0, 1'b0, 5'd9, 1'b1);
        wb_value = 32'hABCD0009;
        id_raddr_a = 5'd9; id_raddr_b = 5'd10;
        #1;
        chk("R9 bypass a", id_rdata_a, 32'hABCD0009);
        chk("R9 other b", id_rdata_b, 32'h0);
        @(negedge clk);
        wb_wen = 1'b0; wb_value = 32'h55;
        #1;
        chk("R8 stored", id_rdata_a, 32'hABCD0009);
        @(negedge clk);
        wb_dst = 5'd0; wb_wen = 1'b1; wb_value = 32'hDEAD;
        id_raddr_a = 5'd0;
        #1;
        chk("R8 zero read during write", id_rdata_a, 32'h0);
        @(negedge clk);
        wb_wen = 1'b0;
        #1;
        chk("R8 zero after write", id_rdata_a, 32'h0);
        wb_value = 32'h30;
    endtask

    initial begin
        #((200000) * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_none();
        t_exm();
        t_wb();
        t_both();
        t_nowen();
        t_zero();
        t_indep();
        t_regfile();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule